// File: doc/BRIEF.md
# Serial Setting Register with Readback

This block is a serial slave that holds the 8-bit code for a current-output converter. A host reaches it through three pins: an active-low select, a shift clock and a data line into the block. While the host shifts a new code in, the block shifts the code it held before back out on a data line that has an output enable. The new code reaches the parallel setting output only when the host releases the select line. A separate active-low shutdown input controls the converter's power enable and leaves the held code untouched.

The serial pins are asynchronous to the block. A fast system clock samples them through a synchronizer, and the block acts on the edges it finds there. The host must therefore hold each level of the shift clock and select for a few system clock cycles. The held code comes out of reset at midscale. The converter side reads `setting` and `convOn` directly.

Top module: `serial_setting_reg`

## Requirements
- R1: After reset, `setting` is 8'h80 (midscale), `sdoOe` is 0 and `sdo` is 0.
- R2: A falling edge on `csN` sets `sdoOe` to 1. At the same time `sdo` shows bit 7 of the code currently held in `setting`.
- R3: The block samples `sdi` on each rising edge of `sclk` while selected. The first bit sampled becomes bit 7 of the committed code, so data enters most significant bit first.
- R4: `sdo` changes only on falling edges of `sclk`. After the k-th falling edge it shows bit 7-k of the previously held code (k < 8). After the 8th falling edge it shows the first bit received, which is the output of a 9-stage path.
- R5: A rising edge on `csN` copies the received word into `setting` and returns `sdoOe` to 0, with `sdo` at 0.
- R6: `setting` does not change while a transfer is in progress. It changes only at the release of `csN`.
- R7: If more than 8 clock pulses are given, the last 8 bits received are committed.
- R8: If n < 8 clock pulses are given, the committed word is `{old[7-n:0], received n bits}`.
- R9: Edges on `sclk` while `csN` is high change neither `setting` nor `sdo`/`sdoOe`. The next transfer reads back the code currently held.
- R10: Driving `shutdownN` low clears `convOn` and leaves `setting` unchanged. Driving it high sets `convOn` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; its fall starts a transfer and its rise commits the word |
| sclk | input | 1 | Serial shift clock from the host |
| sdi | input | 1 | Serial data into the block, most significant bit first |
| shutdownN | input | 1 | Active-low converter shutdown |
| setting | output | 8 | Held converter code |
| sdo | output | 1 | Serial readback of the previously held code |
| sdoOe | output | 1 | Output enable for the `sdo` pad driver |
| convOn | output | 1 | Converter power enable, registered copy of `shutdownN` |

## Verification
The bench builds the block with its defaults: an 8-bit word (a 9-stage readback path) and a two-stage pin synchronizer. The 8-bit width keeps the midscale reset value, the all-ones and all-zeros words, and both the over-length and under-length transfers short enough to run in full. The two-stage synchronizer fixes the pin-to-action latency. The bench then holds each pin level for four system cycles, which is enough to sample every readback bit after its falling edge and every committed word after select release.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Pin indices into the synchronized pin vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SDI  = 2;
  localparam int N_PINS   = 3;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic startXfer;   // load readback path from held code
    logic captureBit;  // write serial input into the path's first stage
    logic advanceOut;  // move the path one stage toward the output
    logic commitWord;  // copy received word into the held code
  } sregStrobes_t;

endpackage

// File: rtl/sreg_pin_sync.sv
module sreg_pin_sync #(
  parameter int N_PINS      = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_PINS-1:0] RESET_BITS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PINS-1:0] pinsRaw,
  output logic [N_PINS-1:0] pinsSync
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= {SYNC_STAGES{RESET_BITS[p]}};
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], pinsRaw[p]};
      end
    end

    assign pinsSync[p] = chain[LAST];
  end

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csLevel,
  input  logic         sclkLevel,
  output sregStrobes_t strobes,
  output logic         busy
);

  logic csPrev;
  logic sclkPrev;
  logic csFall;
  logic csRise;
  logic sclkRise;
  logic sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csLevel;
      sclkPrev <= sclkLevel;
    end
  end

  always_comb begin
    csFall   = csPrev & ~csLevel;
    csRise   = ~csPrev & csLevel;
    sclkRise = ~sclkPrev & sclkLevel;
    sclkFall = sclkPrev & ~sclkLevel;
  end

  // Transfer window: opened by select fall, closed by select rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (csFall) begin
      busy <= 1'b1;
    end else if (csRise) begin
      busy <= 1'b0;
    end
  end

  // Shift clock edges count only inside the window
  always_comb begin
    strobes.startXfer  = csFall & ~busy;
    strobes.captureBit = busy & sclkRise;
    strobes.advanceOut = busy & sclkFall;
    strobes.commitWord = busy & csRise;
  end

endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] RESET_WORD = {1'b1, {(WORD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  sregStrobes_t      strobes,
  input  logic              sdiLevel,
  input  logic              shutdownN,
  output logic [WORD_W-1:0] setting,
  output logic              pathMsb,
  output logic              convOn
);

  localparam int PATH_W = WORD_W + 1;

  logic [PATH_W-1:0] shiftPath;

  // Stage 0 takes serial input; the top stage drives readback
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftPath <= '0;
    end else if (strobes.startXfer) begin
      shiftPath <= {setting, 1'b0};
    end else if (strobes.captureBit) begin
      shiftPath[0] <= sdiLevel;
    end else if (strobes.advanceOut) begin
      shiftPath <= {shiftPath[PATH_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setting <= RESET_WORD;
    end else if (strobes.commitWord) begin
      setting <= shiftPath[PATH_W-1:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convOn <= 1'b0;
    end else begin
      convOn <= shutdownN;
    end
  end

  assign pathMsb = shiftPath[PATH_W-1];

endmodule

// File: rtl/serial_setting_reg.sv
module serial_setting_reg
  import sreg_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              shutdownN,
  output logic [WORD_W-1:0] setting,
  output logic              sdo,
  output logic              sdoOe,
  output logic              convOn
);

  localparam logic [N_PINS-1:0] PIN_RESET = N_PINS'(1 << PIN_CS);

  logic [N_PINS-1:0] pinsRaw;
  logic [N_PINS-1:0] pinsSync;
  sregStrobes_t      strobes;
  logic              busy;
  logic              pathMsb;

  always_comb begin
    pinsRaw           = '0;
    pinsRaw[PIN_CS]   = csN;
    pinsRaw[PIN_SCLK] = sclk;
    pinsRaw[PIN_SDI]  = sdi;
  end

  sreg_pin_sync #(
    .N_PINS      (N_PINS),
    .SYNC_STAGES (SYNC_STAGES),
    .RESET_BITS  (PIN_RESET)
  ) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .pinsRaw  (pinsRaw),
    .pinsSync (pinsSync)
  );

  sreg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csLevel   (pinsSync[PIN_CS]),
    .sclkLevel (pinsSync[PIN_SCLK]),
    .strobes   (strobes),
    .busy      (busy)
  );

  sreg_datapath #(
    .WORD_W (WORD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sdiLevel  (pinsSync[PIN_SDI]),
    .shutdownN (shutdownN),
    .setting   (setting),
    .pathMsb   (pathMsb),
    .convOn    (convOn)
  );

  assign sdoOe = busy;
  assign sdo   = busy & pathMsb;

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] setting,
  input logic              sdo,
  input logic              sdoOe
);

  // R2
  readback_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> sdo == setting[WORD_W-1]);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdo);

  // R6
  commit_only_at_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(setting) |-> $fell(sdoOe));

  // R6
  hold_during_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe)) |-> $stable(setting));

  // R9
  hold_while_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sdoOe && $past(!sdoOe)) |-> $stable(setting));

endmodule

bind serial_setting_reg sreg_checker #(.WORD_W(WORD_W)) u_sreg_checker (
  .clk     (clk),
  .rstN    (rstN),
  .setting (setting),
  .sdo     (sdo),
  .sdoOe   (sdoOe)
);

// File: tb/serial_setting_reg_bench.sv
module serial_setting_reg_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic shutdownN = 1'b1;
  logic [W-1:0] setting;
  logic sdo;
  logic sdoOe;
  logic convOn;

  always #4 clk = ~clk;  // 125 MHz

  serial_setting_reg u_serial_setting_reg (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .sdi       (sdi),
    .shutdownN (shutdownN),
    .setting   (setting),
    .sdo       (sdo),
    .sdoOe     (sdoOe),
    .convOn    (convOn)
  );

  // sel: 0 setting, 1 sdo, 2 sdoOe, 3 convOn
  typedef struct {
    string    req;
    string    what;
    int       sel;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int nChecked = 0;
  int nFail = 0;
  bit done = 0;
  logic [7:0] model;

  // Monitor: compares queued expectations at the falling clock edge
  initial begin
    item_t it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.sel)
          0: act = setting;
          1: act = {7'b0, sdo};
          2: act = {7'b0, sdoOe};
          default: act = {7'b0, convOn};
        endcase
        nChecked++;
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s %s: actual %h expected %h", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic expectItem(string req, string what, int sel, logic [7:0] e);
    item_t it;
    it.req = req; it.what = what; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask

  // Driver: one transfer of n bits, MSB first from bits[n-1]
  task automatic doXfer(input logic [15:0] bits, input int n, input string req);
    logic [7:0] old;
    logic [7:0] acc;
    old = model;
    acc = model;
    csN = 1'b0;
    settle();
    expectItem("R2", "oe on select", 2, 8'h01);
    expectItem(req, "readback first bit", 1, {7'b0, old[7]});
    for (int k = 0; k < n; k++) begin
      logic b;
      b = bits[n-1-k];
      sdi = b;
      settle();
      sclk = 1'b1;
      settle();
      sclk = 1'b0;
      settle();
      acc = {acc[6:0], b};
      expectItem("R4", "sdo after fall", 1, {7'b0, acc[7]});
      if (k == 3) expectItem("R6", "setting held mid-transfer", 0, old);
    end
    csN = 1'b1;
    settle();
    model = acc;
    expectItem(req, "committed word", 0, model);
    expectItem("R5", "oe off after release", 2, 8'h00);
    expectItem("R5", "sdo idle after release", 1, 8'h00);
    settle();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    settle();
    model = 8'h80;
    expectItem("R1", "reset setting", 0, 8'h80);
    expectItem("R1", "reset oe", 2, 8'h00);
    expectItem("R1", "reset sdo", 1, 8'h00);
    expectItem("R10", "conv enabled", 3, 8'h01);
    settle();

    doXfer(16'h00A5, 8, "R5");
    doXfer(16'h003C, 8, "R3");
    doXfer(16'h00FF, 8, "R5");
    doXfer(16'h0000, 8, "R5");
    doXfer(16'h0369, 10, "R7");
    doXfer(16'h0006, 3, "R8");

    // R9: shift clock pulses with select high
    for (int k = 0; k < 5; k++) begin
      sdi = k[0];
      settle();
      sclk = 1'b1;
      settle();
      sclk = 1'b0;
      settle();
      expectItem("R9", "setting ignores idle clock", 0, model);
      expectItem("R9", "oe stays off", 2, 8'h00);
    end
    doXfer(16'h00F0, 8, "R9");

    // R10: shutdown keeps the held code
    shutdownN = 1'b0;
    settle();
    expectItem("R10", "conv disabled", 3, 8'h00);
    expectItem("R10", "setting kept in shutdown", 0, model);
    settle();
    shutdownN = 1'b1;
    settle();
    expectItem("R10", "conv re-enabled", 3, 8'h01);
    expectItem("R10", "setting kept after wake", 0, model);
    settle();
    doXfer(16'h005A, 8, "R10");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecked++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFail);
      $finish;
    end
  end

endmodule